// File: doc/BRIEF.md
# Expansion Bus I/O Port Slave

This block is the adapter-side target for a legacy 8/16-bit expansion bus I/O port window. It captures the system address while the address latch strobe is high and holds it after the strobe falls. Only the low ten address bits are compared against a parameterised window base, and the whole block stays silent while a DMA controller owns the bus (address-enable high). A hit drives the 16-bit size line low at once, before any command strobe, so that hosts which sample it early see a 16-bit port. Reads and writes go to a small internal byte store. Byte lanes are chosen from the latched address bit 0 and the latched high-byte enable, so word transfers and split byte transfers are both accepted.

The data bus is split into an input, an output and a per-lane output enable. The size line and the channel-ready line are open-drain, so each is modelled as an active-high pull-low enable. While the back end reports busy during a decoded command, the block holds channel-ready low. A hold counter releases the line after `MAX_HOLD` clock cycles even if busy never clears, which keeps the bus free for memory refresh.

Top module: `isa_io_slave`

## Requirements
- R1: After reset, data_oe_o is 2'b00, io16_en_o is 0 and rdy_low_o is 0, and no port decodes until a first address latch strobe has been seen.
- R2: addr_i and sbhe_ni are captured on every clock edge while ale_i is high, and they are held while ale_i is low. A change on addr_i after ale_i falls has no effect on the cycle in progress.
- R3: A port hits when latched address bits [9:0] lie in BASE_ADDR .. BASE_ADDR+2**WIN_BITS-1 (BASE_ADDR aligned to the window). Address bits above bit 9 are ignored, so 0x1300 aliases 0x300.
- R4: While aen_i is high the block drives no data enable, no size line and no ready stretch, and it writes nothing.
- R5: With PORT16=1, io16_en_o is high whenever the latched address hits and aen_i is low, with no command strobe active.
- R6: Latched bit0=0 with sbhe_ni=0 is a word access: low lane = even byte, high lane = odd byte, data_oe_o=2'b11.
- R7: Latched bit0=0 with sbhe_ni=1 is an even-byte access on the low lane only, data_oe_o=2'b01.
- R8: Latched bit0=1 with sbhe_ni=0 is an odd-byte access on the high lane data[15:8], data_oe_o=2'b10.
- R9: Latched bit0=1 with sbhe_ni=1 is an odd-byte access carried on the low lane data[7:0], data_oe_o=2'b01.
- R10: data_oe_o is non-zero only while ior_ni is low and the port hits.
- R11: During a hitting command, rdy_low_o is high for as long as busy_i is high, and it drops in the same cycle busy_i falls.
- R12: rdy_low_o stays high for at most MAX_HOLD consecutive clock cycles within one command, even if busy_i stays high.
- R13: A write is committed once per command, on the first clock edge with iow_ni low, a hit and rdy_low_o low, using data_i from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, samples bus signals |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address latch strobe, address captured while high |
| aen_i | input | 1 | DMA owns the bus when high |
| addr_i | input | ADDR_W | System address lines |
| sbhe_ni | input | 1 | High byte enable, active low |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| data_i | input | 16 | Data bus as received |
| busy_i | input | 1 | Back end not ready |
| data_o | output | 16 | Data bus as driven on reads |
| data_oe_o | output | 2 | Output enable per byte lane, bit1 = high lane |
| io16_en_o | output | 1 | Pull the 16-bit size line low |
| rdy_low_o | output | 1 | Pull channel-ready low (stretch the cycle) |

## Verification
The assertions assume the host follows the bus protocol. The address is latched before a command strobe goes low, read and write strobes are never active together, and aen_i does not change inside a command. The bench follows these rules in every scenario. It presents the address with ale_i for one cycle and drops ale_i. It then asserts exactly one strobe, and it changes busy_i or data_i only inside a command that is already running. In the DMA scenario aen_i is set high before the address phase and held high until both strobes have returned high.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

  // lane routing for one access, from latched bit0 and high-byte enable
  typedef struct packed {
    logic wr_even;
    logic wr_odd;
    logic oe_lo;
    logic oe_hi;
    logic odd_on_lo;
  } lane_t;

  function automatic lane_t lane_map(input logic a0, input logic sbhe_n);
    lane_t l;
    l.wr_even   = ~a0;
    l.wr_odd    = a0 | ~sbhe_n;
    l.oe_lo     = ~(a0 & ~sbhe_n);
    l.oe_hi     = ~sbhe_n;
    l.odd_on_lo = a0 & sbhe_n;
    return l;
  endfunction

endpackage

// File: rtl/isa_addr_latch.sv
module isa_addr_latch #(
  parameter int DEC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ale_i,
  input  logic [DEC_W-1:0] addr_i,
  input  logic             sbhe_ni,
  output logic [DEC_W-1:0] lat_addr_o,
  output logic             lat_sbhe_no,
  output logic             lat_valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_o  <= '0;
      lat_sbhe_no <= 1'b1;
      lat_valid_o <= 1'b0;
    end else if (ale_i) begin
      lat_addr_o  <= addr_i;
      lat_sbhe_no <= sbhe_ni;
      lat_valid_o <= 1'b1;
    end
  end

endmodule

// File: rtl/isa_ready_ctl.sv
module isa_ready_ctl #(
  parameter int MAX_HOLD = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_hit_i,
  input  logic cmd_idle_i,
  input  logic busy_i,
  output logic rdy_low_o,
  output logic go_o
);

  localparam int CNT_W = $clog2(MAX_HOLD + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_HOLD);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign rdy_low_o = cmd_hit_i & busy_i & (cnt_q != LIMIT);
  assign go_o      = cmd_hit_i & ~rdy_low_o & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cmd_idle_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (rdy_low_o) cnt_q <= cnt_q + 1'b1;
      if (go_o)      done_q <= 1'b1;
    end
  end

  // R12
  hold_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit_i && busy_i && !rdy_low_o) |-> (cnt_q == LIMIT));

  // R13
  go_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !cmd_idle_i) |=> !go_o);

  // R13
  go_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !rdy_low_o);

endmodule

// File: rtl/isa_byte_regs.sv
module isa_byte_regs #(
  parameter int WIN_BITS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WIN_BITS-2:0] word_i,
  input  logic                we_even_i,
  input  logic                we_odd_i,
  input  logic [7:0]          wd_even_i,
  input  logic [7:0]          wd_odd_i,
  output logic [7:0]          rd_even_o,
  output logic [7:0]          rd_odd_o
);

  localparam int NWORD = 2 ** (WIN_BITS - 1);

  logic [7:0] even_q [NWORD];
  logic [7:0] odd_q  [NWORD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORD; i++) begin
        even_q[i] <= '0;
        odd_q[i]  <= '0;
      end
    end else begin
      if (we_even_i) even_q[word_i] <= wd_even_i;
      if (we_odd_i)  odd_q[word_i]  <= wd_odd_i;
    end
  end

  assign rd_even_o = even_q[word_i];
  assign rd_odd_o  = odd_q[word_i];

endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
  import isa_io_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEC_W     = 10,
  parameter int BASE_ADDR = 'h300,
  parameter int WIN_BITS  = 3,
  parameter bit PORT16    = 1'b1,
  parameter int MAX_HOLD  = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              aen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sbhe_ni,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic [15:0]       data_i,
  input  logic              busy_i,
  output logic [15:0]       data_o,
  output logic [1:0]        data_oe_o,
  output logic              io16_en_o,
  output logic              rdy_low_o
);

  localparam logic [DEC_W-1:0] BASE_V = DEC_W'(BASE_ADDR);

  logic [DEC_W-1:0] lat_addr;
  logic             lat_sbhe_n, lat_valid;
  logic             hit, cmd_hit, cmd_idle, go;
  logic [7:0]       rd_even, rd_odd, wd_odd;
  lane_t            lane;

  isa_addr_latch #(.DEC_W(DEC_W)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ale_i      (ale_i),
    .addr_i     (addr_i[DEC_W-1:0]),
    .sbhe_ni    (sbhe_ni),
    .lat_addr_o (lat_addr),
    .lat_sbhe_no(lat_sbhe_n),
    .lat_valid_o(lat_valid)
  );

  // only the decoded bits take part; upper address lines alias
  assign hit      = lat_valid & ~aen_i
                  & (lat_addr[DEC_W-1:WIN_BITS] == BASE_V[DEC_W-1:WIN_BITS]);
  assign cmd_idle = ior_ni & iow_ni;
  assign cmd_hit  = hit & ~cmd_idle;
  assign lane     = lane_map(lat_addr[0], lat_sbhe_n);

  isa_ready_ctl #(.MAX_HOLD(MAX_HOLD)) u_ready (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_hit_i (cmd_hit),
    .cmd_idle_i(cmd_idle),
    .busy_i    (busy_i),
    .rdy_low_o (rdy_low_o),
    .go_o      (go)
  );

  assign wd_odd = lane.odd_on_lo ? data_i[7:0] : data_i[15:8];

  isa_byte_regs #(.WIN_BITS(WIN_BITS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_i   (lat_addr[WIN_BITS-1:1]),
    .we_even_i(go & ~iow_ni & lane.wr_even),
    .we_odd_i (go & ~iow_ni & lane.wr_odd),
    .wd_even_i(data_i[7:0]),
    .wd_odd_i (wd_odd),
    .rd_even_o(rd_even),
    .rd_odd_o (rd_odd)
  );

  assign data_o    = {rd_odd, lane.odd_on_lo ? rd_odd : rd_even};
  assign data_oe_o = (hit & ~ior_ni) ? {lane.oe_hi, lane.oe_lo} : 2'b00;
  assign io16_en_o = PORT16 & hit;

  // R4
  dma_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> (data_oe_o == 2'b00 && !io16_en_o && !rdy_low_o));

  // R10
  rd_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != 2'b00) |-> (!ior_ni && !aen_i && lat_valid));

  // R5
  size_before_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PORT16 && data_oe_o != 2'b00) |-> io16_en_o);

  // R11
  stretch_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_low_o |-> (busy_i && !cmd_idle && !aen_i));

endmodule

// File: tb/sim_isa_io_slave.sv
module sim_isa_io_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ale_i = 1'b0, aen_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        sbhe_ni = 1'b1, ior_ni = 1'b1, iow_ni = 1'b1;
  logic [15:0] data_i = '0;
  logic        busy_i = 1'b0;
  logic [15:0] data_o;
  logic [1:0]  data_oe_o;
  logic        io16_en_o, rdy_low_o;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  isa_io_slave #(.MAX_HOLD(HOLD)) u0 (
    .clk_i, .rst_ni, .ale_i, .aen_i, .addr_i, .sbhe_ni, .ior_ni, .iow_ni,
    .data_i, .busy_i, .data_o, .data_oe_o, .io16_en_o, .rdy_low_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [15:0] a, input logic sb);
    @(negedge clk_i);
    addr_i = a; sbhe_ni = sb; ale_i = 1'b1;
    @(negedge clk_i);
    ale_i = 1'b0;
    #1;
  endtask

  task automatic t_write(input logic [15:0] a, input logic sb, input logic [15:0] d,
                         input bit exp_hit, input string req);
    addr_phase(a, sb);
    chk(io16_en_o == exp_hit, {req, " R5 io16 before strobe"}, io16_en_o, exp_hit);
    data_i = d; iow_ni = 1'b0;
    @(negedge clk_i);
    iow_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_read(input logic [15:0] a, input logic sb, input logic [1:0] exp_oe,
                        input logic [15:0] exp_d, input logic [15:0] mask, input string req);
    addr_phase(a, sb);
    chk(data_oe_o == 2'b00, {req, " R10 oe before strobe"}, data_oe_o, 0);
    ior_ni = 1'b0;
    #1;
    chk(data_oe_o == exp_oe, {req, " oe"}, data_oe_o, exp_oe);
    chk((data_o & mask) == (exp_d & mask), {req, " data"}, data_o & mask, exp_d & mask);
    @(negedge clk_i);
    ior_ni = 1'b1;
    #1;
    chk(data_oe_o == 2'b00, {req, " R10 oe after strobe"}, data_oe_o, 0);
  endtask

  task automatic t_reset;
    #1;
    chk(data_oe_o == 2'b00 && !io16_en_o && !rdy_low_o, "R1 reset outputs",
        {data_oe_o, io16_en_o, rdy_low_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    ior_ni = 1'b0;
    #1;
    chk(data_oe_o == 2'b00, "R1 no decode before latch strobe", data_oe_o, 0);
    @(negedge clk_i);
    ior_ni = 1'b1;
  endtask

  task automatic t_lanes;
    t_write(16'h0300, 1'b0, 16'hBEEF, 1'b1, "R6");
    t_read (16'h0300, 1'b0, 2'b11, 16'hBEEF, 16'hFFFF, "R6 word read");
    t_write(16'h0302, 1'b1, 16'hAA11, 1'b1, "R7");
    t_write(16'h0303, 1'b0, 16'h2255, 1'b1, "R8");
    t_read (16'h0302, 1'b0, 2'b11, 16'h2211, 16'hFFFF, "R7 R8 word after byte writes");
    t_read (16'h0302, 1'b1, 2'b01, 16'h0011, 16'h00FF, "R7 even byte read");
    t_read (16'h0303, 1'b0, 2'b10, 16'h2200, 16'hFF00, "R8 odd byte high lane");
    t_write(16'h0305, 1'b1, 16'hCC33, 1'b1, "R9");
    t_read (16'h0305, 1'b1, 2'b01, 16'h0033, 16'h00FF, "R9 odd byte low lane");
    t_read (16'h0304, 1'b0, 2'b11, 16'h3300, 16'hFFFF, "R9 word view");
  endtask

  task automatic t_latch_hold;
    addr_phase(16'h0300, 1'b0);
    addr_i = 16'h03F0; sbhe_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(io16_en_o == 1'b1, "R2 decode held after ale low", io16_en_o, 1);
    ior_ni = 1'b0;
    #1;
    chk(data_oe_o == 2'b11 && data_o == 16'hBEEF, "R2 held address and sbhe",
        data_o, 16'hBEEF);
    @(negedge clk_i);
    ior_ni = 1'b1;
  endtask

  task automatic t_decode;
    t_read (16'h1300, 1'b0, 2'b11, 16'hBEEF, 16'hFFFF, "R3 upper bits alias");
    t_read (16'h0308, 1'b0, 2'b00, 16'h0000, 16'h0000, "R3 above window");
    chk(io16_en_o == 1'b0, "R3 no io16 above window", io16_en_o, 0);
    t_read (16'h02FF, 1'b1, 2'b00, 16'h0000, 16'h0000, "R3 below window");
    t_write(16'h0307, 1'b1, 16'h0077, 1'b1, "R3 top of window");
    t_read (16'h0307, 1'b1, 2'b01, 16'h0077, 16'h00FF, "R3 top of window read");
  endtask

  task automatic t_dma;
    @(negedge clk_i);
    aen_i = 1'b1;
    addr_phase(16'h0300, 1'b0);
    chk(io16_en_o == 1'b0, "R4 no io16 with aen", io16_en_o, 0);
    busy_i = 1'b1; data_i = 16'h1234; iow_ni = 1'b0;
    #1;
    chk(rdy_low_o == 1'b0, "R4 no stretch with aen", rdy_low_o, 0);
    @(negedge clk_i);
    iow_ni = 1'b1; ior_ni = 1'b0;
    #1;
    chk(data_oe_o == 2'b00, "R4 no read drive with aen", data_oe_o, 0);
    @(negedge clk_i);
    ior_ni = 1'b1; busy_i = 1'b0;
    @(negedge clk_i);
    aen_i = 1'b0;
    t_read(16'h0300, 1'b0, 2'b11, 16'hBEEF, 16'hFFFF, "R4 write ignored");
  endtask

  task automatic t_stretch;
    int lows = 0;
    busy_i = 1'b1;
    addr_phase(16'h0306, 1'b0);
    data_i = 16'h1111; iow_ni = 1'b0;
    for (int k = 0; k < 8; k++) begin
      #1;
      if (rdy_low_o) lows++;
      if (k == 1) data_i = 16'hCAFE;
      if (k == 2) begin
        busy_i = 1'b0;
        #1;
        chk(rdy_low_o == 1'b0, "R11 release with busy", rdy_low_o, 0);
      end
      @(negedge clk_i);
    end
    chk(lows == 3, "R11 stretch length", lows, 3);
    data_i = 16'h9999;
    @(negedge clk_i);
    iow_ni = 1'b1;
    @(negedge clk_i);
    t_read(16'h0306, 1'b0, 2'b11, 16'hCAFE, 16'hFFFF, "R13 data at release, once");
  endtask

  task automatic t_watchdog;
    int lows = 0;
    busy_i = 1'b1;
    addr_phase(16'h0300, 1'b0);
    data_i = 16'h5A5A; iow_ni = 1'b0;
    for (int k = 0; k < 3 * HOLD; k++) begin
      #1;
      if (rdy_low_o) lows++;
      @(negedge clk_i);
    end
    chk(lows == HOLD, "R12 hold limit", lows, HOLD);
    iow_ni = 1'b1;
    @(negedge clk_i);
    busy_i = 1'b0;
    t_read(16'h0300, 1'b0, 2'b11, 16'h5A5A, 16'hFFFF, "R13 commit after forced release");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lanes();
    t_latch_hold();
    t_decode();
    t_dma();
    t_stretch();
    t_watchdog();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule